// File: doc/BRIEF.md
# Software-Refilled Translation Buffer with Random Slot Replacement

This block is a fully associative address translation buffer. Every cycle it can take one lookup: a virtual address, an address-space tag and a load/store flag. One cycle later it reports a physical address with a hit, or one fault. A miss raises its own exception output, kept apart from the general exception output, so the processor can send it to a dedicated handler. An entry found with its valid bit clear, or a store to an entry that is not dirty, raises the general exception instead. On any fault the block keeps the full faulting address and copies the faulting page number into the staging register.

The block never walks page tables. Software loads a staging register with a complete entry and then issues a command. An indexed write stores the staged entry at the slot held in the index register. A random write stores it at the slot named by a free-running down-counter, which only covers slots 8 to 63. Slots 0 to 7 can therefore only change through an indexed write, which keeps them safe for long-lived mappings. A probe command searches for the staged page number and tag. It reports the matching slot through the index register, or sets a not-found flag.

Top module: `sw_tlb`

## Requirements
- R1: The buffer has 64 slots. A lookup (lk_req=1) that matches a loaded slot on page number (lk_va[31:12]) and on tag reports lk_hit=1 on the next cycle, with lk_pa = {frame, lk_va[11:0]}. When several slots match, the lowest-numbered slot is used.
- R2: A lookup that matches no loaded slot sets lk_fault=2'b01 and miss_exc=1 on the next cycle, with gen_exc=0 and lk_hit=0.
- R3: A lookup that matches a slot whose valid bit is 0 sets lk_fault=2'b10 and gen_exc=1, with miss_exc=0 and lk_hit=0.
- R4: A store (lk_store=1) that matches a valid slot whose dirty bit is 0 sets lk_fault=2'b11 and gen_exc=1. A load to that slot hits, and so does a store to a dirty slot.
- R5: On every fault, badva_q takes the full lookup address and stg_vpn_q takes its page number. A cycle without a lookup request raises no exception and changes neither register.
- R6: rand_q is 63 after reset and decrements on every clock. From 8 it wraps to 63, so it always lies between 8 and 63.
- R7: The random-write command (cmd=2'b10) stores the staged entry at slot rand_q. Slots 0 to 7 are never changed by it.
- R8: idx_wr loads idx_i into idx_q. The indexed-write command (cmd=2'b01) stores the staged entry at slot idx_q, which may be any of 0 to 63.
- R9: The probe command (cmd=2'b11) searches for the staged page number and tag. On a match it loads the lowest matching slot into idx_q and clears probe_miss_q. Without a match it sets probe_miss_q and leaves idx_q unchanged.
- R10: After reset no slot is loaded, so every lookup misses. idx_q, probe_miss_q, stg_vpn_q, badva_q, lk_hit and both exception outputs are 0.
- R11: A slot with its global bit set matches regardless of the tag. A slot without it matches only when its tag equals the lookup tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 6 | Lookup address-space tag |
| lk_store | input | 1 | Lookup is a store |
| lk_hit | output | 1 | Translation succeeded (one cycle after request) |
| lk_pa | output | 32 | Translated physical address |
| lk_fault | output | 2 | 00 none, 01 miss, 10 invalid, 11 modify |
| miss_exc | output | 1 | Miss exception request (own vector) |
| gen_exc | output | 1 | General exception request |
| stg_wr | input | 1 | Load staging register from the stg_*_i inputs |
| stg_vpn_i | input | 20 | Staged page number |
| stg_asid_i | input | 6 | Staged tag |
| stg_glob_i | input | 1 | Staged global bit |
| stg_pfn_i | input | 20 | Staged frame number |
| stg_valid_i | input | 1 | Staged valid bit |
| stg_dirty_i | input | 1 | Staged dirty bit |
| idx_wr | input | 1 | Load index register |
| idx_i | input | 6 | Index register write value |
| cmd | input | 2 | 00 none, 01 indexed write, 10 random write, 11 probe |
| stg_vpn_q | output | 20 | Staged page number readback |
| idx_q | output | 6 | Index register |
| probe_miss_q | output | 1 | Probe not-found flag |
| rand_q | output | 6 | Random replacement slot |
| badva_q | output | 32 | Faulting virtual address |

## Verification
The assertions assume that lk_req, cmd, stg_wr and idx_wr are 0 or 1 cleanly from the first clock after reset. They also assume that software never issues a staging write, a command and a faulting lookup in the same cycle. Because of that, the priority among those updates is not part of any property. The bench drives one operation per cycle and starts each one at the falling edge, so this ordering is always respected. Its random mix draws page numbers and tags from a small pool, so matches, duplicate matches, global slots and overwrites all occur often.

// File: rtl/tlbr_pkg.sv
package tlbr_pkg;
    localparam int VPN_W  = 20;
    localparam int OFF_W  = 12;
    localparam int ASID_W = 6;
    localparam int PFN_W  = 20;
    localparam int VA_W   = VPN_W + OFF_W;
    localparam int PA_W   = PFN_W + OFF_W;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic [PFN_W-1:0]  pfn;
        logic              valid;
        logic              dirty;
    } tlb_ent_t;

    typedef enum logic [1:0] {
        FK_NONE  = 2'b00,
        FK_MISS  = 2'b01,
        FK_INVAL = 2'b10,
        FK_MOD   = 2'b11
    } fault_e;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_WIDX  = 2'b01,
        CMD_WRAND = 2'b10,
        CMD_PROBE = 2'b11
    } cmd_e;

    function automatic logic tag_match(input tlb_ent_t e,
                                       input logic [VPN_W-1:0] vpn,
                                       input logic [ASID_W-1:0] asid);
        return (e.vpn == vpn) && (e.glob || (e.asid == asid));
    endfunction
endpackage

// File: rtl/tlbr_rand.sv
module tlbr_rand #(
    parameter int N     = 64,
    parameter int LOW   = 8,
    localparam int W    = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] idx
);
    always_ff @(posedge clk) begin
        if (rst)                  idx <= W'(N - 1);
        else if (idx == W'(LOW))  idx <= W'(N - 1);
        else                      idx <= idx - 1'b1;
    end
endmodule

// File: rtl/tlbr_cam.sv
module tlbr_cam
    import tlbr_pkg::*;
#(
    parameter int N  = 64,
    localparam int W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [W-1:0]      widx,
    input  tlb_ent_t          wdata,
    input  logic [VPN_W-1:0]  q_vpn,
    input  logic [ASID_W-1:0] q_asid,
    output logic              q_hit,
    output tlb_ent_t          q_ent,
    input  logic [VPN_W-1:0]  p_vpn,
    input  logic [ASID_W-1:0] p_asid,
    output logic              p_hit,
    output logic [W-1:0]      p_idx
);
    tlb_ent_t       ent [N];
    logic [N-1:0]   used;
    logic [N-1:0]   q_m, p_m;
    logic [W-1:0]   q_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            used <= '0;
            for (int i = 0; i < N; i++) ent[i] <= '0;
        end else if (we) begin
            used[widx] <= 1'b1;
            ent[widx]  <= wdata;
        end
    end

    generate
        for (genvar g = 0; g < N; g++) begin : g_cmp
            assign q_m[g] = used[g] && tag_match(ent[g], q_vpn, q_asid);
            assign p_m[g] = used[g] && tag_match(ent[g], p_vpn, p_asid);
        end
    endgenerate

    // lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        q_hit = 1'b0;
        q_idx = '0;
        p_hit = 1'b0;
        p_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (q_m[i]) begin
                q_hit = 1'b1;
                q_idx = W'(i);
            end
            if (p_m[i]) begin
                p_hit = 1'b1;
                p_idx = W'(i);
            end
        end
    end

    assign q_ent = ent[q_idx];
endmodule

// File: rtl/sw_tlb.sv
module sw_tlb
    import tlbr_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int WIRED   = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_store,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_pa,
    output logic [1:0]        lk_fault,
    output logic              miss_exc,
    output logic              gen_exc,
    input  logic              stg_wr,
    input  logic [VPN_W-1:0]  stg_vpn_i,
    input  logic [ASID_W-1:0] stg_asid_i,
    input  logic              stg_glob_i,
    input  logic [PFN_W-1:0]  stg_pfn_i,
    input  logic              stg_valid_i,
    input  logic              stg_dirty_i,
    input  logic              idx_wr,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [1:0]        cmd,
    output logic [VPN_W-1:0]  stg_vpn_q,
    output logic [IDX_W-1:0]  idx_q,
    output logic              probe_miss_q,
    output logic [IDX_W-1:0]  rand_q,
    output logic [VA_W-1:0]   badva_q
);
    tlb_ent_t         stg;
    tlb_ent_t         q_ent;
    logic             q_hit, p_hit;
    logic [IDX_W-1:0] p_idx;
    logic             cam_we;
    logic [IDX_W-1:0] cam_widx;
    fault_e           fk, res_fault;
    logic             fault_now;

    tlbr_rand #(.N(ENTRIES), .LOW(WIRED)) u_rand (
        .clk (clk),
        .rst (rst),
        .idx (rand_q)
    );

    assign cam_we   = (cmd == CMD_WIDX) || (cmd == CMD_WRAND);
    assign cam_widx = (cmd == CMD_WRAND) ? rand_q : idx_q;

    tlbr_cam #(.N(ENTRIES)) u_cam (
        .clk    (clk),
        .rst    (rst),
        .we     (cam_we),
        .widx   (cam_widx),
        .wdata  (stg),
        .q_vpn  (lk_va[VA_W-1:OFF_W]),
        .q_asid (lk_asid),
        .q_hit  (q_hit),
        .q_ent  (q_ent),
        .p_vpn  (stg.vpn),
        .p_asid (stg.asid),
        .p_hit  (p_hit),
        .p_idx  (p_idx)
    );

    always_comb begin
        if (!q_hit)                         fk = FK_MISS;
        else if (!q_ent.valid)              fk = FK_INVAL;
        else if (lk_store && !q_ent.dirty)  fk = FK_MOD;
        else                                fk = FK_NONE;
    end

    assign fault_now = lk_req && (fk != FK_NONE);

    // lookup result stage
    always_ff @(posedge clk) begin
        if (rst) begin
            res_fault <= FK_NONE;
            lk_hit    <= 1'b0;
            lk_pa     <= '0;
            badva_q   <= '0;
        end else begin
            res_fault <= lk_req ? fk : FK_NONE;
            lk_hit    <= lk_req && (fk == FK_NONE);
            lk_pa     <= (lk_req && (fk == FK_NONE)) ? {q_ent.pfn, lk_va[OFF_W-1:0]} : '0;
            if (fault_now) badva_q <= lk_va;
        end
    end

    // staging register: software write takes priority over fault capture
    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else if (stg_wr) begin
            stg.vpn   <= stg_vpn_i;
            stg.asid  <= stg_asid_i;
            stg.glob  <= stg_glob_i;
            stg.pfn   <= stg_pfn_i;
            stg.valid <= stg_valid_i;
            stg.dirty <= stg_dirty_i;
        end else if (fault_now) begin
            stg.vpn   <= lk_va[VA_W-1:OFF_W];
        end
    end

    // index register and probe flag
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q        <= '0;
            probe_miss_q <= 1'b0;
        end else if (cmd == CMD_PROBE) begin
            probe_miss_q <= !p_hit;
            if (p_hit) idx_q <= p_idx;
        end else if (idx_wr) begin
            idx_q <= idx_i;
        end
    end

    assign stg_vpn_q = stg.vpn;
    assign lk_fault  = res_fault;
    assign miss_exc  = (res_fault == FK_MISS);
    assign gen_exc   = (res_fault == FK_INVAL) || (res_fault == FK_MOD);
endmodule

// File: rtl/tlbr_chk.sv
module tlbr_chk
    import tlbr_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int WIRED   = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input logic              clk,
    input logic              rst,
    input logic              lk_req,
    input logic [VA_W-1:0]   lk_va,
    input logic              lk_hit,
    input logic [1:0]        lk_fault,
    input logic              miss_exc,
    input logic              gen_exc,
    input logic [IDX_W-1:0]  rand_q,
    input logic [VA_W-1:0]   badva_q,
    input logic [VPN_W-1:0]  stg_vpn_q,
    input logic              stg_wr
);
    AST_EXC_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(miss_exc && gen_exc));                                          // R2
    AST_HIT_CLEAN: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (!miss_exc && !gen_exc && lk_fault == 2'b00));         // R1
    AST_MISS_CODE: assert property (@(posedge clk) disable iff (rst)
        miss_exc |-> (lk_fault == 2'b01));                                // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> (!miss_exc && !gen_exc && !lk_hit));                  // R5
    AST_BADVA_CAPT: assert property (@(posedge clk) disable iff (rst)
        (lk_req && !stg_wr) |=> ((miss_exc || gen_exc) ->
            (badva_q == $past(lk_va) && stg_vpn_q == $past(lk_va[VA_W-1:OFF_W])))); // R5
    AST_RAND_RANGE: assert property (@(posedge clk) disable iff (rst)
        rand_q >= IDX_W'(WIRED));                                         // R6
    AST_RAND_STEP: assert property (@(posedge clk) disable iff (rst)
        (rand_q != IDX_W'(WIRED)) |=> (rand_q == $past(rand_q) - 1'b1));  // R6
    AST_RAND_WRAP: assert property (@(posedge clk) disable iff (rst)
        (rand_q == IDX_W'(WIRED)) |=> (rand_q == IDX_W'(ENTRIES - 1)));   // R6
endmodule

bind sw_tlb tlbr_chk #(.ENTRIES(ENTRIES), .WIRED(WIRED)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_req    (lk_req),
    .lk_va     (lk_va),
    .lk_hit    (lk_hit),
    .lk_fault  (lk_fault),
    .miss_exc  (miss_exc),
    .gen_exc   (gen_exc),
    .rand_q    (rand_q),
    .badva_q   (badva_q),
    .stg_vpn_q (stg_vpn_q),
    .stg_wr    (stg_wr)
);

// File: tb/sim_sw_tlb.sv
`timescale 1ns/1ps
module sim_sw_tlb;
    logic        clk = 1'b0;
    logic        rst;
    logic        lk_req, lk_store, lk_hit, miss_exc, gen_exc;
    logic [31:0] lk_va, lk_pa, badva_q;
    logic [5:0]  lk_asid, stg_asid_i, idx_i, idx_q, rand_q;
    logic [1:0]  lk_fault, cmd;
    logic        stg_wr, stg_glob_i, stg_valid_i, stg_dirty_i, idx_wr, probe_miss_q;
    logic [19:0] stg_vpn_i, stg_pfn_i, stg_vpn_q;

    always #4 clk = ~clk;

    sw_tlb u0 (.*);

    // bench model
    logic [19:0] m_vpn [64];
    logic [5:0]  m_asid [64];
    logic [19:0] m_pfn [64];
    logic        m_glob [64], m_val [64], m_dirty [64], m_used [64];
    logic [19:0] s_vpn, s_pfn;
    logic [5:0]  s_asid;
    logic        s_glob, s_val, s_dirty;
    logic [5:0]  m_idx, m_rand;
    logic        m_pmiss;
    logic [31:0] m_badva;
    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always @(posedge clk) begin
        if (rst) m_rand <= 6'd63;
        else     m_rand <= (m_rand == 6'd8) ? 6'd63 : m_rand - 6'd1;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int find(input logic [19:0] vpn, input logic [5:0] asid);
        for (int i = 0; i < 64; i++)
            if (m_used[i] && m_vpn[i] == vpn && (m_glob[i] || m_asid[i] == asid)) return i;
        return -1;
    endfunction

    task automatic stage(input logic [19:0] vpn, input logic [5:0] asid, input logic g,
                         input logic [19:0] pfn, input logic v, input logic d);
        stg_wr = 1; stg_vpn_i = vpn; stg_asid_i = asid; stg_glob_i = g;
        stg_pfn_i = pfn; stg_valid_i = v; stg_dirty_i = d;
        @(posedge clk);
        s_vpn = vpn; s_asid = asid; s_glob = g; s_pfn = pfn; s_val = v; s_dirty = d;
        @(negedge clk);
        stg_wr = 0;
    endtask

    task automatic load_idx(input logic [5:0] i);
        idx_wr = 1; idx_i = i;
        @(posedge clk);
        m_idx = i;
        @(negedge clk);
        idx_wr = 0;
        chk("R8 idx_q load", idx_q, i);
    endtask

    task automatic do_write(input bit rnd);
        int slot;
        slot = rnd ? int'(m_rand) : int'(m_idx);
        cmd = rnd ? 2'b10 : 2'b01;
        @(posedge clk);
        m_used[slot] = 1; m_vpn[slot] = s_vpn; m_asid[slot] = s_asid; m_glob[slot] = s_glob;
        m_pfn[slot] = s_pfn; m_val[slot] = s_val; m_dirty[slot] = s_dirty;
        @(negedge clk);
        cmd = 2'b00;
        if (rnd) chk("R7 random slot in 8..63", 64'(slot >= 8), 64'd1);
    endtask

    task automatic do_probe();
        int f;
        f = find(s_vpn, s_asid);
        cmd = 2'b11;
        @(posedge clk);
        if (f >= 0) begin m_idx = 6'(f); m_pmiss = 0; end
        else m_pmiss = 1;
        @(negedge clk);
        cmd = 2'b00;
        chk("R9 probe idx", idx_q, m_idx);
        chk("R9 probe not-found", probe_miss_q, m_pmiss);
    endtask

    task automatic lookup(input logic [31:0] va, input logic [5:0] asid, input logic st);
        int f;
        logic [1:0] ef;
        logic [31:0] epa;
        f = find(va[31:12], asid);
        epa = 0;
        if (f < 0) ef = 2'b01;
        else if (!m_val[f]) ef = 2'b10;
        else if (st && !m_dirty[f]) ef = 2'b11;
        else begin ef = 2'b00; epa = {m_pfn[f], va[11:0]}; end
        lk_req = 1; lk_va = va; lk_asid = asid; lk_store = st;
        @(posedge clk);
        if (ef != 2'b00) begin m_badva = va; s_vpn = va[31:12]; end
        @(negedge clk);
        lk_req = 0;
        chk("R1 lk_hit", lk_hit, ef == 2'b00);
        chk("R1 lk_pa", lk_pa, epa);
        chk("R3/R4 lk_fault", lk_fault, ef);
        chk("R2 miss_exc", miss_exc, ef == 2'b01);
        chk("R3 gen_exc", gen_exc, ef[1]);
        chk("R5 badva_q", badva_q, m_badva);
        chk("R5 stg_vpn_q", stg_vpn_q, s_vpn);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1; lk_req = 0; lk_va = 0; lk_asid = 0; lk_store = 0;
        stg_wr = 0; stg_vpn_i = 0; stg_asid_i = 0; stg_glob_i = 0; stg_pfn_i = 0;
        stg_valid_i = 0; stg_dirty_i = 0; idx_wr = 0; idx_i = 0; cmd = 0;
        for (int i = 0; i < 64; i++) begin
            m_used[i] = 0; m_vpn[i] = 0; m_asid[i] = 0; m_pfn[i] = 0;
            m_glob[i] = 0; m_val[i] = 0; m_dirty[i] = 0;
        end
        s_vpn = 0; s_pfn = 0; s_asid = 0; s_glob = 0; s_val = 0; s_dirty = 0;
        m_idx = 0; m_pmiss = 0; m_badva = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R10 reset state
        chk("R10 idx_q", idx_q, 0);
        chk("R10 probe_miss_q", probe_miss_q, 0);
        chk("R10 badva_q", badva_q, 0);
        chk("R10 stg_vpn_q", stg_vpn_q, 0);
        chk("R10 exceptions", {lk_hit, miss_exc, gen_exc}, 0);
        chk("R6 rand_q after first clock", rand_q, m_rand);
        lookup(32'h0000_0123, 6'd0, 0);   // R10 empty buffer misses

        // R6 free-running sequence incl. wrap
        for (int k = 0; k < 70; k++) begin
            @(negedge clk);
            chk("R6 rand_q", rand_q, m_rand);
        end
        // R5 no request: nothing changes
        chk("R5 idle no exc", {miss_exc, gen_exc}, 0);

        // fill slots 0..7 by index
        for (int i = 0; i < 8; i++) begin
            stage(20'd100 + 20'(i), 6'd1, i == 3, 20'hA0000 + 20'(i), 1, 1);
            load_idx(6'(i));
            do_write(0);
        end
        for (int i = 0; i < 8; i++) lookup({20'd100 + 20'(i), 12'h5A5}, 6'd1, 1); // R1
        lookup({20'd103, 12'h001}, 6'd9, 0);  // R11 global ignores tag
        lookup({20'd102, 12'h001}, 6'd9, 0);  // R11 tag mismatch misses
        // R3 invalid, R4 clean store
        stage(20'd200, 6'd1, 0, 20'h12345, 0, 0); load_idx(6'd10); do_write(0);
        stage(20'd201, 6'd1, 0, 20'h54321, 1, 0); load_idx(6'd63); do_write(0);
        lookup({20'd200, 12'h0}, 6'd1, 0);
        lookup({20'd201, 12'hFFF}, 6'd1, 0);
        lookup({20'd201, 12'hFFF}, 6'd1, 1);
        // R9 probe found / not found
        stage(20'd201, 6'd1, 0, 0, 0, 0); load_idx(6'd5); do_probe();
        stage(20'd999, 6'd1, 0, 0, 0, 0); do_probe();
        // R1 duplicate: lowest index wins
        stage(20'd104, 6'd1, 0, 20'hBBBBB, 1, 1); load_idx(6'd40); do_write(0);
        lookup({20'd104, 12'h010}, 6'd1, 0);

        // R7 wired slots survive many random writes
        stage(20'd50, 6'd0, 1, 20'hCCCCC, 1, 1);
        for (int k = 0; k < 300; k++) do_write(1);
        for (int i = 0; i < 8; i++) lookup({20'd100 + 20'(i), 12'h0}, 6'd1, 0);

        // constrained random mix
        for (int k = 0; k < 4000; k++) begin
            int op;
            op = int'($urandom_range(0, 9));
            case (op)
                0, 1: stage(20'($urandom_range(0, 15)), 6'($urandom_range(0, 3)),
                            $urandom_range(0, 7) == 0, 20'($urandom()),
                            $urandom_range(0, 7) != 0, $urandom_range(0, 3) != 0);
                2: load_idx(6'($urandom_range(0, 63)));
                3: do_write(0);
                4: do_write(1);
                5: do_probe();
                default: lookup({20'($urandom_range(0, 15)), 12'($urandom())},
                                6'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
            endcase
            if (k % 50 == 0) chk("R6 rand_q", rand_q, m_rand);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule